// File: doc/BRIEF.md
# Serial Channel Loopback Mode Router

This block sits between one serial channel's transmitter core, its receiver core and the channel's external transmit and receive pins. It picks one of four operating modes: normal, automatic echo, local loopback and remote loopback. It steers the serial bit streams to match the selected mode. It also gates the processor's write strobe toward the transmitter and its read strobe from the receiver, because some diagnostic modes cut those links.

A requested mode is not applied at once. It is committed only on a clock edge at which both the transmitter and the receiver report idle, so a character in flight is never cut in half. Until that edge the previous mode stays in force and the request waits.

Both echo paths send the received pin value back out through one register stage. This leaves no combinational path from the receive pin to the transmit pin.

Top module: `loopback_router`

## Requirements
- R1: After a synchronous reset the active mode is normal and the echo register holds mark (1).
- R2: In normal mode (code 00), tx_pin equals tx_core_out, rx_core_in equals rx_pin, and both CPU strobes pass through unchanged.
- R3: In automatic echo mode (code 01), tx_pin shows the rx_pin value sampled at the most recent clock edge, read strobes pass and write strobes are blocked (0).
- R4: In local loopback mode (code 10), rx_core_in equals tx_core_out, tx_pin is held at mark (1), and both CPU strobes pass.
- R5: In remote loopback mode (code 11), tx_pin shows the rx_pin value sampled at the most recent clock edge, and both CPU strobes are blocked (0).
- R6: In every mode except local loopback, rx_core_in equals rx_pin.
- R7: The active mode changes only on a clock edge at which tx_idle and rx_idle are both 1. A request made while either core is busy is held, and the old mode stays in force.
- R8: In both echo modes, tx_pin does not change between clock edges when rx_pin toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested mode: 00 normal, 01 echo, 10 local loop, 11 remote loop |
| tx_idle | input | 1 | Transmitter core reports no character in progress |
| rx_idle | input | 1 | Receiver core reports no character in progress |
| rx_pin | input | 1 | External serial receive pin |
| tx_core_out | input | 1 | Serial output of the transmitter core |
| cpu_wr | input | 1 | Processor write strobe toward the transmitter |
| cpu_rd | input | 1 | Processor read strobe from the receiver |
| tx_pin | output | 1 | External serial transmit pin |
| rx_core_in | output | 1 | Serial input to the receiver core |
| tx_wr_gated | output | 1 | Write strobe after mode gating |
| rx_rd_gated | output | 1 | Read strobe after mode gating |

## Verification
A wrong committed mode shows up at the ports in the first cycle after the faulty edge. The pin routing and the strobe gating then disagree with the requested mode, and the bench checks every routed output against every input pattern in each mode. A commit that ignores the idle handshake shows up as early gating or routing while a core is still busy. A missing or extra echo stage shows up as a one-cycle slip on tx_pin, or as tx_pin following an rx_pin toggle in the middle of a cycle.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ECHO   = 2'b01,
        MODE_LOCAL  = 2'b10,
        MODE_REMOTE = 2'b11
    } chan_mode_e;

    localparam logic MARK_LEVEL = 1'b1;

    typedef struct packed {
        logic tx_from_echo;
        logic tx_force_mark;
        logic rx_from_tx;
        logic wr_allow;
        logic rd_allow;
    } route_ctl_t;

    function automatic route_ctl_t decode_mode(chan_mode_e m);
        route_ctl_t c;
        c.tx_from_echo  = (m == MODE_ECHO) || (m == MODE_REMOTE);
        c.tx_force_mark = (m == MODE_LOCAL);
        c.rx_from_tx    = (m == MODE_LOCAL);
        c.wr_allow      = (m == MODE_NORMAL) || (m == MODE_LOCAL);
        c.rd_allow      = (m != MODE_REMOTE);
        return c;
    endfunction

endpackage

// File: rtl/lbr_mode_commit.sv
module lbr_mode_commit
    import lbr_pkg::*;
#(
    parameter chan_mode_e RESET_MODE = MODE_NORMAL
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req,
    input  logic       tx_idle,
    input  logic       rx_idle,
    output chan_mode_e active_mode
);
    chan_mode_e active_q;
    logic       both_idle;

    assign both_idle = tx_idle && rx_idle;

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= RESET_MODE;
        else if (both_idle)
            active_q <= chan_mode_e'(mode_req);
    end

    assign active_mode = active_q;

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        !both_idle |=> $stable(active_q)); // R7
    AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        both_idle |=> (active_q == chan_mode_e'($past(mode_req)))); // R7

endmodule

// File: rtl/lbr_echo_stage.sv
module lbr_echo_stage
    import lbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_pin,
    output logic echo_bit
);
    logic echo_q;

    always_ff @(posedge clk) begin
        if (rst)
            echo_q <= MARK_LEVEL;
        else
            echo_q <= rx_pin;
    end

    assign echo_bit = echo_q;

    AST_ECHO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (echo_bit == $past(rx_pin))); // R8

endmodule

// File: rtl/lbr_path_mux.sv
module lbr_path_mux
    import lbr_pkg::*;
(
    input  chan_mode_e active_mode,
    input  logic       echo_bit,
    input  logic       rx_pin,
    input  logic       tx_core_out,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    output logic       tx_pin,
    output logic       rx_core_in,
    output logic       tx_wr_gated,
    output logic       rx_rd_gated
);
    route_ctl_t ctl;

    always_comb begin
        ctl = decode_mode(active_mode);
        if (ctl.tx_force_mark)
            tx_pin = MARK_LEVEL;
        else if (ctl.tx_from_echo)
            tx_pin = echo_bit;
        else
            tx_pin = tx_core_out;
        rx_core_in  = ctl.rx_from_tx ? tx_core_out : rx_pin;
        tx_wr_gated = cpu_wr && ctl.wr_allow;
        rx_rd_gated = cpu_rd && ctl.rd_allow;
    end

endmodule

// File: rtl/loopback_router.sv
module loopback_router
    import lbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req,
    input  logic       tx_idle,
    input  logic       rx_idle,
    input  logic       rx_pin,
    input  logic       tx_core_out,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    output logic       tx_pin,
    output logic       rx_core_in,
    output logic       tx_wr_gated,
    output logic       rx_rd_gated
);
    chan_mode_e active_mode;
    logic       echo_bit;

    lbr_mode_commit #(.RESET_MODE(MODE_NORMAL)) commit_i (
        .clk(clk), .rst(rst), .mode_req(mode_req),
        .tx_idle(tx_idle), .rx_idle(rx_idle), .active_mode(active_mode)
    );

    lbr_echo_stage echo_i (
        .clk(clk), .rst(rst), .rx_pin(rx_pin), .echo_bit(echo_bit)
    );

    lbr_path_mux mux_i (
        .active_mode(active_mode), .echo_bit(echo_bit), .rx_pin(rx_pin),
        .tx_core_out(tx_core_out), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .tx_pin(tx_pin), .rx_core_in(rx_core_in),
        .tx_wr_gated(tx_wr_gated), .rx_rd_gated(rx_rd_gated)
    );

    AST_RESET_NORMAL: assert property (@(posedge clk)
        $past(rst) |-> (active_mode == MODE_NORMAL)); // R1
    AST_ECHO_PIN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (active_mode == MODE_ECHO || active_mode == MODE_REMOTE))
        |-> (tx_pin == $past(rx_pin))); // R3
    AST_LOCAL_MARK: assert property (@(posedge clk) disable iff (rst)
        (active_mode == MODE_LOCAL) |-> (tx_pin && rx_core_in == tx_core_out)); // R4
    AST_REMOTE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (active_mode == MODE_REMOTE) |-> (!tx_wr_gated && !rx_rd_gated)); // R5
    AST_RX_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
        (active_mode != MODE_LOCAL) |-> (rx_core_in == rx_pin)); // R6

endmodule

// File: tb/loopback_router_tb.sv
module loopback_router_tb_top;
    localparam int CLK_P = 10;

    logic clk = 0, rst = 1;
    logic [1:0] mode_req = 2'b00;
    logic tx_idle = 1, rx_idle = 1, rx_pin = 1, tx_core_out = 1, cpu_wr = 0, cpu_rd = 0;
    logic tx_pin, rx_core_in, tx_wr_gated, rx_rd_gated;
    int checks = 0, failures = 0;

    always #(CLK_P/2) clk = ~clk;

    loopback_router dut_i (
        .clk(clk), .rst(rst), .mode_req(mode_req), .tx_idle(tx_idle), .rx_idle(rx_idle),
        .rx_pin(rx_pin), .tx_core_out(tx_core_out), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .tx_pin(tx_pin), .rx_core_in(rx_core_in),
        .tx_wr_gated(tx_wr_gated), .rx_rd_gated(rx_rd_gated)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_mode(int m, logic rx, logic txo, logic wr, logic rd);
        logic e_tx, e_rxin;
        e_tx   = (m == 0) ? txo : (m == 2) ? 1'b1 : rx;
        e_rxin = (m == 2) ? txo : rx;
        chk(m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5", "tx_pin", tx_pin, e_tx);
        chk(m == 2 ? "R4" : "R6", "rx_core_in", rx_core_in, e_rxin);
        chk(m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5", "tx_wr_gated",
            tx_wr_gated, wr && (m == 0 || m == 2));
        chk(m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5", "rx_rd_gated",
            rx_rd_gated, rd && (m != 3));
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0; tx_core_out = 0; cpu_wr = 1; cpu_rd = 1;
        #1;
        chk("R1", "tx_pin normal after reset", tx_pin, 1'b0);
        chk("R1", "wr passes after reset", tx_wr_gated, 1'b1);
        chk("R1", "rd passes after reset", rx_rd_gated, 1'b1);

        // Exhaustive sweep per mode
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            mode_req = 2'(m); tx_idle = 1; rx_idle = 1;
            @(posedge clk);
            for (int p = 0; p < 16; p++) begin
                @(negedge clk);
                rx_pin = p[0]; tx_core_out = p[1]; cpu_wr = p[2]; cpu_rd = p[3];
                @(posedge clk);
                #1;
                check_mode(m, p[0], p[1], p[2], p[3]);
                if (m == 1 || m == 3) begin
                    // R8: toggle rx between edges, tx_pin must hold
                    rx_pin = ~p[0];
                    #1;
                    chk("R8", "tx_pin stable mid-cycle", tx_pin, p[0]);
                end
            end
        end

        // R7: pending request while busy
        @(negedge clk);
        mode_req = 2'b00; tx_idle = 1; rx_idle = 1; cpu_wr = 1; cpu_rd = 1;
        @(posedge clk);
        @(negedge clk);
        mode_req = 2'b11; tx_idle = 0; rx_idle = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R7", "tx busy keeps normal wr", tx_wr_gated, 1'b1);
        chk("R7", "tx busy keeps normal rd", rx_rd_gated, 1'b1);
        @(negedge clk);
        tx_idle = 1; rx_idle = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R7", "rx busy keeps normal wr", tx_wr_gated, 1'b1);
        @(negedge clk);
        tx_idle = 0; rx_idle = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R7", "both busy keeps normal rd", rx_rd_gated, 1'b1);
        @(negedge clk);
        tx_idle = 1; rx_idle = 1;
        #1;
        chk("R7", "no commit before edge", tx_wr_gated, 1'b1);
        @(posedge clk);
        #1;
        chk("R7", "commit to remote blocks wr", tx_wr_gated, 1'b0);
        chk("R7", "commit to remote blocks rd", rx_rd_gated, 1'b0);

        // R1: reset returns to normal from remote
        @(negedge clk);
        rst = 1; tx_idle = 0; rx_idle = 0; rx_pin = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 0; tx_core_out = 1;
        #1;
        chk("R1", "reset restores normal wr", tx_wr_gated, 1'b1);
        chk("R1", "reset restores normal tx_pin", tx_pin, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule